// File: doc/BRIEF.md
# Reciprocal Frequency and Duty Capture Unit

This block measures a digital input over a window made of whole input periods and reports two 32-bit numbers captured together. The window always opens and closes on rising edges of the selected input. The first number is the elapsed system-clock count of the window. The second number is either the count of input periods in the window (frequency mode) or the count of system clocks during which the input was high (duty mode). Software divides the two numbers to obtain frequency or duty cycle. That division is not part of this block.

The window length comes from a cycle-count setting. A nonzero setting closes the window after that many input periods, and the closing edge opens the next window at once, so measurements run back to back. A setting of zero hands pacing to software. Arming opens a window on the next rising edge. A stop request then closes it on the first rising edge that follows, and the unit goes idle. A policy input decides whether a pending result is protected until it is read, or replaced by each newer result. Reading the result clears the ready flag. If the ready flag stays low after arming, software can treat the input as static or disconnected.

The measured signal is picked from neighbouring pins or from the pin's own output bit by a 4-bit selector, optionally inverted. It is then resynchronised to the system clock.

Top module: `recip_capture`

## Requirements
- R1: `src_sel_i[2:0]` picks the source: 000 own pin (`OWN_PIN`), 001/010/011 pin +1/+2/+3, 100 `own_out_i`, 101/110/111 pin -3/-2/-1. Pin indices wrap modulo `PINS`. `src_sel_i[3]`=1 inverts the chosen source before measurement.
- R2: The selected signal passes through a two-flop synchroniser before rising-edge detection. After `arm_i`, a window opens on the first detected rising edge.
- R3: `period_o` holds the number of system clocks from the opening rising edge to the closing rising edge of the captured window.
- R4: With `duty_mode_i`=0, `count_o` holds the number of input periods in the captured window.
- R5: With `duty_mode_i`=1, `count_o` holds the number of system clocks in the window during which the input was high.
- R6: With `ncyc_i`≠0, a window closes on its `ncyc_i`-th rising edge after opening. That same edge opens the next window.
- R7: With `ncyc_i`=0, a window never closes by itself. It closes on the first rising edge after a cycle with `stop_i`=1, and the unit then stays idle until the next `arm_i`.
- R8: With `hold_first_i`=1, results arriving while `ready_o`=1 are discarded. After a read, the next result is accepted.
- R9: With `hold_first_i`=0, each new result replaces the previous one even when it has not been read.
- R10: `rd_i` clears `ready_o` on the next cycle, unless a result is accepted in that same cycle.
- R11: `arm_i` clears `ready_o` and abandons any window in progress. With no rising edges on the input, `ready_o` stays low.
- R12: All counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | PINS | Raw input pins of the pin group |
| own_out_i | input | 1 | Output bit of this pin, selectable as a source |
| src_sel_i | input | 4 | Source selector; bit 3 inverts |
| duty_mode_i | input | 1 | 0 = count input periods, 1 = count high clocks |
| hold_first_i | input | 1 | 1 = keep unread result, 0 = overwrite |
| ncyc_i | input | NW | Window length in input periods; 0 = software paced |
| arm_i | input | 1 | Pulse: restart measurement, clear ready |
| stop_i | input | 1 | Pulse: request end of a software-paced window |
| rd_i | input | 1 | Pulse: result has been read |
| period_o | output | CW | Captured system-clock count of the window |
| count_o | output | CW | Captured period count or high-clock count |
| ready_o | output | 1 | A result is waiting to be read |

## Verification
The bench drives a square wave with a known period and high time onto one pin. It checks the pair through every selector code, including wrap-around below pin zero and inversion. A design off by one in the period or high count, reading the wrong neighbour, or ignoring the invert bit shows up as an exact mismatch against period × cycles and high time × cycles. The policy tests change the high time while a result is pending. A design that overwrites under hold-first, or holds under overwrite, then reports the wrong high count. Software pacing is checked for a window that never closes without a stop, and for idling after its one capture. A narrow-counter instance with a window longer than its range must read all ones rather than a wrapped value.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } win_state_e;

  localparam int SEL_W     = 4;
  localparam int SRC_CODES = 8;
  localparam int OUT_CODE  = 4;
endpackage

// File: rtl/rfc_input_sel.sv
module rfc_input_sel
  import rfc_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int OWN_PIN = 2
) (
  input  logic [PINS-1:0]  pins_i,
  input  logic             own_out_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sig_o
);
  logic [SRC_CODES-1:0] cand;

  // Codes 0..3 reach upward, 5..7 downward (two's complement), 4 is the output bit.
  for (genvar k = 0; k < SRC_CODES; k++) begin : g_cand
    if (k == OUT_CODE) begin : g_out
      assign cand[k] = own_out_i;
    end else begin : g_pin
      localparam int OFF = (k < OUT_CODE) ? k : k - SRC_CODES;
      localparam int IDX = (OWN_PIN + PINS + OFF) % PINS;
      assign cand[k] = pins_i[IDX];
    end
  end

  assign sig_o = cand[sel_i[2:0]] ^ sel_i[3];

  initial begin
    assert (PINS >= 4 && OWN_PIN < PINS) else $error("rfc_input_sel: bad pin geometry");
  end
endmodule

// File: rtl/rfc_sync_edge.sv
module rfc_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign level_o = sh_q[1];
  assign rise_o  = sh_q[1] & ~sh_q[2];

  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rfc_pair_count.sv
module rfc_pair_count #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          rise_i,
  input  logic          level_i,
  output logic [CW-1:0] elapsed_o,
  output logic [CW-1:0] cycles_o,
  output logic [CW-1:0] high_o
);
  logic [CW-1:0] el_q, el_d;
  logic [CW-1:0] cy_q, cy_d;
  logic [CW-1:0] hi_q, hi_d;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_comb begin
    el_d = el_q;
    cy_d = cy_q;
    hi_d = hi_q;
    if (start_i) begin
      el_d = {{(CW-1){1'b0}}, 1'b1};
      cy_d = '0;
      hi_d = {{(CW-1){1'b0}}, level_i};
    end else if (run_i) begin
      el_d = sat_inc(el_q);
      if (rise_i)  cy_d = sat_inc(cy_q);
      if (level_i) hi_d = sat_inc(hi_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      el_q <= '0;
      cy_q <= '0;
      hi_q <= '0;
    end else begin
      el_q <= el_d;
      cy_q <= cy_d;
      hi_q <= hi_d;
    end
  end

  assign elapsed_o = el_q;
  assign cycles_o  = sat_inc(cy_q);
  assign high_o    = hi_q;

  p_no_wrap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && (&el_q)) |=> (&el_q));
  p_high_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q <= el_q);
endmodule

// File: rtl/rfc_window_fsm.sv
module rfc_window_fsm
  import rfc_pkg::*;
#(
  parameter int NW = 16,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic [NW-1:0] ncyc_i,
  input  logic          rise_i,
  input  logic [CW-1:0] cycles_i,
  output logic          start_o,
  output logic          run_o,
  output logic          cap_o
);
  localparam int CMPW = (CW > NW) ? CW : NW;

  win_state_e state_q, state_d;
  logic       stop_q, stop_d;
  logic       sw_mode, reached;

  assign sw_mode = (ncyc_i == '0);
  assign reached = CMPW'(cycles_i) >= CMPW'(ncyc_i);

  always_comb begin
    state_d = state_q;
    stop_d  = stop_q;
    start_o = 1'b0;
    cap_o   = 1'b0;
    if (arm_i) begin
      state_d = ST_WAIT;
      stop_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_WAIT: begin
          if (stop_i) stop_d = 1'b1;
          if (rise_i) begin
            state_d = ST_RUN;
            start_o = 1'b1;
          end
        end
        ST_RUN: begin
          if (stop_i) stop_d = 1'b1;
          if (rise_i && (sw_mode ? stop_q : reached)) begin
            cap_o = 1'b1;
            if (sw_mode) begin
              state_d = ST_IDLE;
              stop_d  = 1'b0;
            end else begin
              start_o = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end

  assign run_o = (state_q == ST_RUN);

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !arm_i) |=> (state_q == ST_IDLE));
  p_sw_oneshot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && ncyc_i == '0) |=> (state_q == ST_IDLE));
  p_fixed_rerun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && ncyc_i != '0) |=> (state_q == ST_RUN));
endmodule

// File: rtl/recip_capture.sv
module recip_capture
  import rfc_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int OWN_PIN = 2,
  parameter int CW      = 32,
  parameter int NW      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PINS-1:0]  pins_i,
  input  logic             own_out_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             duty_mode_i,
  input  logic             hold_first_i,
  input  logic [NW-1:0]    ncyc_i,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic             rd_i,
  output logic [CW-1:0]    period_o,
  output logic [CW-1:0]    count_o,
  output logic             ready_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic          sig, level, rise;
  logic          start, run, cap;
  logic [CW-1:0] elapsed, cycles, high;

  rfc_input_sel #(.PINS(PINS), .OWN_PIN(OWN_PIN)) u_sel (
    .pins_i   (pins_i),
    .own_out_i(own_out_i),
    .sel_i    (src_sel_i),
    .sig_o    (sig)
  );

  rfc_sync_edge u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (sig),
    .level_o(level),
    .rise_o (rise)
  );

  rfc_window_fsm #(.NW(NW), .CW(CW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .arm_i   (arm_i),
    .stop_i  (stop_i),
    .ncyc_i  (ncyc_i),
    .rise_i  (rise),
    .cycles_i(cycles),
    .start_o (start),
    .run_o   (run),
    .cap_o   (cap)
  );

  rfc_pair_count #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (start),
    .run_i    (run),
    .rise_i   (rise),
    .level_i  (level),
    .elapsed_o(elapsed),
    .cycles_o (cycles),
    .high_o   (high)
  );

  // Result pair and ready flag.
  logic [CW-1:0] per_q, per_d, cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic [CW-1:0] second;
  logic          accept;

  assign second = duty_mode_i ? high : cycles;
  assign accept = cap & ~(hold_first_i & rdy_q & ~rd_i);

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (arm_i) begin
      rdy_d = 1'b0;
    end else if (accept) begin
      per_d = elapsed;
      cnt_d = second;
      rdy_d = 1'b1;
    end else if (rd_i) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign period_o = per_q;
  assign count_o  = cnt_q;
  assign ready_o  = rdy_q;

  p_hold_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hold_first_i && ready_o && !rd_i && !arm_i) |=> ($stable(period_o) && $stable(count_o)));
  p_rd_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_i && !cap && !arm_i) |=> !ready_o);
  p_arm_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    arm_i |=> !ready_o);
  p_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cap && !hold_first_i && !arm_i) |=> ready_o);
endmodule

// File: tb/recip_capture_test.sv
`timescale 1ns/1ps
module recip_capture_test;
  localparam int PINS = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PINS-1:0] pins;
  logic            own_out;
  logic [3:0]      sel;
  logic            duty, hold, arm, stop, rd;
  logic [15:0]     ncyc;
  logic [31:0]     period, count;
  logic            ready;
  logic [7:0]      nperiod, ncount;
  logic            nready;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  recip_capture #(.PINS(PINS), .OWN_PIN(2), .CW(32), .NW(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .own_out_i(own_out),
    .src_sel_i(sel), .duty_mode_i(duty), .hold_first_i(hold), .ncyc_i(ncyc),
    .arm_i(arm), .stop_i(stop), .rd_i(rd),
    .period_o(period), .count_o(count), .ready_o(ready));

  recip_capture #(.PINS(PINS), .OWN_PIN(2), .CW(8), .NW(16)) uut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .own_out_i(own_out),
    .src_sel_i(sel), .duty_mode_i(duty), .hold_first_i(hold), .ncyc_i(ncyc),
    .arm_i(arm), .stop_i(stop), .rd_i(rd),
    .period_o(nperiod), .count_o(ncount), .ready_o(nready));

  // Square-wave source: period gen_p clocks, high for gen_h clocks.
  logic        gen_en;
  logic [3:0]  gen_src;
  int unsigned gen_p, gen_h, gph;
  logic        gwave;

  always @(negedge clk) begin
    if (!gen_en) gph <= 0;
    else         gph <= (gph + 1 >= gen_p) ? 0 : gph + 1;
  end
  assign gwave = gen_en && (gph < gen_h);

  always_comb begin
    pins    = '0;
    own_out = 1'b0;
    if (gen_src == 4'd8) own_out = gwave;
    else                 pins[gen_src[2:0]] = gwave;
  end

  typedef struct packed {
    logic [3:0]  src;
    logic [3:0]  sel;
    logic        duty;
    logic [7:0]  n;
    logic [7:0]  p;
    logic [7:0]  h;
    logic [15:0] exp_per;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{4'd2, 4'b0000, 1'b0, 8'd4, 8'd10, 8'd3,  16'd40, 16'd4},
    '{4'd3, 4'b0001, 1'b1, 8'd3, 8'd12, 8'd5,  16'd36, 16'd15},
    '{4'd5, 4'b0011, 1'b1, 8'd2, 8'd9,  8'd2,  16'd18, 16'd4},
    '{4'd8, 4'b0100, 1'b0, 8'd5, 8'd6,  8'd3,  16'd30, 16'd5},
    '{4'd7, 4'b0101, 1'b1, 8'd2, 8'd10, 8'd4,  16'd20, 16'd8},
    '{4'd1, 4'b1111, 1'b1, 8'd3, 8'd8,  8'd3,  16'd24, 16'd15},
    '{4'd0, 4'b1110, 1'b0, 8'd1, 8'd7,  8'd2,  16'd7,  16'd1},
    '{4'd4, 4'b0010, 1'b1, 8'd1, 8'd20, 8'd19, 16'd20, 16'd19}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_arm();
    arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int t = 0; t < lim && !ready; t++) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; stop = 1'b0; rd = 1'b0;
    sel = 4'b0000; duty = 1'b0; hold = 1'b0; ncyc = 16'd0;
    gen_en = 1'b0; gen_src = 4'd2; gen_p = 10; gen_h = 4;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    check("reset ready", {31'd0, ready}, 32'd0);
    check("reset period", period, 32'd0);
    check("reset count", count, 32'd0);

    // Vector table: R1 selection, R3 period, R4/R5 second count, R6 fixed N
    gen_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      gen_src = VEC[i].src; gen_p = VEC[i].p; gen_h = VEC[i].h;
      sel = VEC[i].sel; duty = VEC[i].duty; ncyc = {8'd0, VEC[i].n};
      repeat (3 * gen_p + 4) @(negedge clk);
      pulse_arm();
      wait_ready(2000);
      check("R1 R3 R6 period", period, {16'd0, VEC[i].exp_per});
      check(VEC[i].duty ? "R1 R5 high count" : "R1 R4 cycle count", count, {16'd0, VEC[i].exp_cnt});
      pulse_rd();
    end

    // Software-paced window: R7 and R10
    gen_src = 4'd2; gen_p = 10; gen_h = 4; sel = 4'b0000; duty = 1'b1; ncyc = 16'd0;
    repeat (30) @(negedge clk);
    pulse_arm();
    repeat (45) @(negedge clk);
    check("R7 no self close", {31'd0, ready}, 32'd0);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    wait_ready(100);
    check("R7 ready after stop", {31'd0, ready}, 32'd1);
    check("R7 whole periods", period % 10, 32'd0);
    check("R7 period range", {31'd0, (period >= 30 && period <= 70)}, 32'd1);
    check("R5 R7 high count", count, (period / 10) * 4);
    pulse_rd();
    check("R10 read clears ready", {31'd0, ready}, 32'd0);
    repeat (60) @(negedge clk);
    check("R7 idle after capture", {31'd0, ready}, 32'd0);

    // Hold-first policy: R8
    ncyc = 16'd2; hold = 1'b1; gen_h = 4;
    pulse_arm();
    wait_ready(200);
    check("R8 first count", count, 32'd8);
    gen_h = 6;
    repeat (70) @(negedge clk);
    check("R8 held count", count, 32'd8);
    check("R8 held ready", {31'd0, ready}, 32'd1);
    pulse_rd();
    wait_ready(200);
    check("R8 recapture after read", count, 32'd12);
    check("R8 recapture period", period, 32'd20);

    // Overwrite policy: R9
    hold = 1'b0; gen_h = 2;
    repeat (70) @(negedge clk);
    check("R9 overwritten count", count, 32'd4);
    check("R9 ready kept", {31'd0, ready}, 32'd1);

    // Arm clears, static input: R11
    pulse_arm();
    check("R11 arm clears ready", {31'd0, ready}, 32'd0);
    gen_en = 1'b0;
    repeat (10) @(negedge clk);
    pulse_arm();
    repeat (150) @(negedge clk);
    check("R11 static input no result", {31'd0, ready}, 32'd0);

    // Saturation: R12
    gen_en = 1'b1; gen_p = 100; gen_h = 90; ncyc = 16'd3; duty = 1'b1;
    repeat (20) @(negedge clk);
    pulse_arm();
    wait_ready(1000);
    check("R12 wide period", period, 32'd300);
    check("R12 wide count", count, 32'd270);
    check("R12 narrow period saturates", {24'd0, nperiod}, 32'd255);
    check("R12 narrow count saturates", {24'd0, ncount}, 32'd255);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule